// File: doc/BRIEF.md
# Battery Charge Mode Sequencer

This block chooses the charging phase of a single lithium-ion cell. Its inputs are comparator results that have already been turned into logic levels: the cell is below the dead-cell threshold, the cell is below the weak-cell threshold, the sense line has reached the termination voltage, the charge current is below the end-of-charge level, and a recharge request. From these it steps through idle, trickle, weak constant-current, fast constant-current, fast constant-voltage, done and fault. It reports the active phase as a 3-bit code, together with a fault flag and a charge-active flag.

The block counts two time limits in pulses of a slow tick input. The trickle limit is fixed at sixty minutes of ticks, and the minute length is set by a parameter. The fast-charge limit is a parameter of its own and covers both fast phases. When the fast limit runs out, the result depends on how far charging has got. If the termination voltage was never seen, the block stops with a fault. If the cell is already in constant-voltage phase, the block stops cleanly. A fault holds until a clear pulse arrives, and the block then returns to idle.

Top module: `chg_phase_seq`

## Requirements
- R1: After reset, phase is 3'b000 (idle), fault is 0 and charging is 0.
- R2: From idle with chg_en high, the next phase depends on the cell voltage. If v_below_dead is high the block enters trickle (3'b001). If only v_below_weak is high it enters weak (3'b011). If neither is high it enters fast constant-current (3'b010).
- R3: In trickle, once v_below_dead falls the block moves to weak or fast constant-current, using v_below_weak to decide. In weak, v_below_dead going high returns the block to trickle, and v_below_weak falling moves it to fast constant-current.
- R4: Trickle ends in fault (3'b111, fault=1, charging=0) one cycle after its tick count reaches 60*TICKS_PER_MIN. With one tick fewer the block is still in trickle.
- R5: In fast constant-current, v_at_term moves the block to fast constant-voltage (3'b100).
- R6: Fast constant-current ends in fault one cycle after the fast tick count reaches FAST_LIMIT. With one tick fewer the block is still in fast constant-current.
- R7: The fast tick count runs across the move from constant-current to constant-voltage. If it reaches FAST_LIMIT while the block is in constant-voltage, the block goes to done (3'b101) and fault stays 0.
- R8: In constant-voltage, i_below_end moves the block to done and fault stays 0.
- R9: In done, recharge_req restarts charging. The block goes to the phase that R2 would choose for the present cell voltage.
- R10: Fault holds while chg_en is low and while recharge_req is high. Only a fault_clr pulse leaves fault, and the block goes to idle.
- R11: Dropping chg_en in any charging phase or in done sends the block to idle. charging is 1 exactly in trickle, weak, fast constant-current and constant-voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| chg_en | input | 1 | Charging allowed |
| v_below_dead | input | 1 | Cell is below the dead-cell threshold |
| v_below_weak | input | 1 | Cell is below the weak-cell threshold |
| v_at_term | input | 1 | Sense line has reached the termination voltage |
| i_below_end | input | 1 | Charge current is below the end-of-charge level |
| recharge_req | input | 1 | Recharge threshold has been crossed |
| fault_clr | input | 1 | Pulse that clears a latched fault |
| phase | output | 3 | Phase code |
| fault | output | 1 | Fault is latched |
| charging | output | 1 | A charging phase is active |

## Verification
The hardest case to reach is a fast-charge timeout that falls inside constant-voltage phase. It needs the fast count to be nearly used up in constant-current, then the termination input, then the final ticks. The bench reaches it by running FAST_LIMIT-2 ticks in constant-current, raising v_at_term, and then sending the last two ticks one at a time. It checks that the phase is still constant-voltage after the first of them and is done, with no fault, after the second. Both timeouts are also tested at one tick short of the limit and at the limit itself, using small tick limits set through the parameters.

// File: rtl/chg_phase_seq.sv
module chg_phase_seq #(
  parameter int TICKS_PER_MIN = 60,
  parameter int FAST_LIMIT    = 18000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       chg_en,
  input  logic       v_below_dead,
  input  logic       v_below_weak,
  input  logic       v_at_term,
  input  logic       i_below_end,
  input  logic       recharge_req,
  input  logic       fault_clr,
  output logic [2:0] phase,
  output logic       fault,
  output logic       charging
);

  localparam int TRK_LIMIT = 60 * TICKS_PER_MIN;
  localparam int TW = $clog2(TRK_LIMIT + 1);
  localparam int FW = $clog2(FAST_LIMIT + 1);

  typedef enum logic [2:0] {
    S_IDLE  = 3'b000,
    S_TRK   = 3'b001,
    S_CC    = 3'b010,
    S_WEAK  = 3'b011,
    S_CV    = 3'b100,
    S_DONE  = 3'b101,
    S_FAULT = 3'b111
  } state_t;

  state_t state, nxt, pick;
  logic [TW-1:0] trk_cnt;
  logic [FW-1:0] fast_cnt;
  logic trk_exp, fast_exp, in_fast;

  assign in_fast  = (state == S_CC) || (state == S_CV);
  assign trk_exp  = (trk_cnt == TW'(TRK_LIMIT));
  assign fast_exp = (fast_cnt == FW'(FAST_LIMIT));
  assign pick     = v_below_dead ? S_TRK : (v_below_weak ? S_WEAK : S_CC);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (chg_en) nxt = pick;
      S_TRK: begin
        if (!chg_en)            nxt = S_IDLE;
        else if (!v_below_dead) nxt = v_below_weak ? S_WEAK : S_CC;
        else if (trk_exp)       nxt = S_FAULT;
      end
      S_WEAK: begin
        if (!chg_en)            nxt = S_IDLE;
        else if (v_below_dead)  nxt = S_TRK;
        else if (!v_below_weak) nxt = S_CC;
      end
      S_CC: begin
        if (!chg_en)        nxt = S_IDLE;
        else if (v_at_term) nxt = S_CV;
        else if (fast_exp)  nxt = S_FAULT;
      end
      S_CV: begin
        if (!chg_en)                      nxt = S_IDLE;
        else if (i_below_end || fast_exp) nxt = S_DONE;
      end
      S_DONE: begin
        if (!chg_en)           nxt = S_IDLE;
        else if (recharge_req) nxt = pick;
      end
      S_FAULT: if (fault_clr) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      trk_cnt  <= '0;
      fast_cnt <= '0;
    end else begin
      state <= nxt;
      if (state != S_TRK)           trk_cnt <= '0;
      else if (tick && !trk_exp)    trk_cnt <= trk_cnt + 1'b1;
      if (!in_fast)                 fast_cnt <= '0;
      else if (tick && !fast_exp)   fast_cnt <= fast_cnt + 1'b1;
    end
  end

  assign phase    = state;
  assign fault    = (state == S_FAULT);
  assign charging = (state == S_TRK) || (state == S_WEAK) || in_fast;

  p_trk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trk_cnt <= TW'(TRK_LIMIT));

  p_trk_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b001 && chg_en && v_below_dead && trk_exp) |=> fault);

  p_cc_to_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b010 && chg_en && v_at_term) |=> (phase == 3'b100));

  p_fault_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(phase) == 3'b001 || $past(phase) == 3'b010));

  p_cv_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b100) |=> !fault);

  p_cv_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b100 && chg_en && i_below_end) |=> (phase == 3'b101));

  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  p_fault_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_clr) |=> (phase == 3'b000));

  p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (charging && !chg_en) |=> (phase == 3'b000));

  p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && charging));

endmodule

// File: tb/chg_phase_seq_tb.sv
module chg_phase_seq_tb_top;
  localparam int TPM  = 2;
  localparam int TRKL = 60 * TPM;
  localparam int FL   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, chg_en = 1'b0, v_below_dead = 1'b0, v_below_weak = 1'b0;
  logic v_at_term = 1'b0, i_below_end = 1'b0, recharge_req = 1'b0, fault_clr = 1'b0;
  logic [2:0] phase;
  logic fault, charging;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  chg_phase_seq #(.TICKS_PER_MIN(TPM), .FAST_LIMIT(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chg_en(chg_en),
    .v_below_dead(v_below_dead), .v_below_weak(v_below_weak),
    .v_at_term(v_at_term), .i_below_end(i_below_end),
    .recharge_req(recharge_req), .fault_clr(fault_clr),
    .phase(phase), .fault(fault), .charging(charging));

  // {en, dead, weak, term, iend, rchg, clr, expected phase}
  localparam logic [9:0] VEC [16] = '{
    {7'b0000000, 3'b000}, {7'b1110000, 3'b001}, {7'b1110000, 3'b001},
    {7'b1010000, 3'b011}, {7'b1110000, 3'b001}, {7'b1000000, 3'b010},
    {7'b1000000, 3'b010}, {7'b1001000, 3'b100}, {7'b1001000, 3'b100},
    {7'b1001100, 3'b101}, {7'b1001100, 3'b101}, {7'b1000010, 3'b010},
    {7'b0000000, 3'b000}, {7'b1010000, 3'b011}, {7'b1000000, 3'b010},
    {7'b0000000, 3'b000}
  };
  localparam string VREQ [16] = '{"R1", "R2", "R3", "R3", "R3", "R3", "R6", "R5",
                                  "R8", "R8", "R9", "R9", "R11", "R2", "R3", "R11"};

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_phase(input string req, input logic [2:0] exp);
    logic exp_chg;
    exp_chg = (exp == 3'b001) || (exp == 3'b011) || (exp == 3'b010) || (exp == 3'b100);
    chk(req, phase, exp);
    chk(req, fault, exp == 3'b111);
    chk(req, charging, exp_chg);
  endtask

  task automatic clk1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      clk1();
      tick = 1'b0;
    end
  endtask

  task automatic set_in(input logic [6:0] v);
    {chg_en, v_below_dead, v_below_weak, v_at_term, i_below_end, recharge_req, fault_clr} = v;
  endtask

  task automatic restart();
    set_in(7'b0);
    rst_n = 1'b0;
    clk1();
    rst_n = 1'b1;
    clk1();
  endtask

  function automatic void summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_phase("R1", 3'b000);
    rst_n = 1'b1;
    clk1();
    chk_phase("R1", 3'b000);

    for (int k = 0; k < 16; k++) begin
      set_in(VEC[k][9:3]);
      clk1();
      chk_phase(VREQ[k], VEC[k][2:0]);
    end

    // R4: trickle timeout boundary
    restart();
    set_in(7'b1110000);
    clk1();
    chk_phase("R2", 3'b001);
    ticks(TRKL - 1);
    clk1();
    chk_phase("R4", 3'b001);
    ticks(1);
    clk1();
    chk_phase("R4", 3'b111);

    // R10: fault holds against enable drop and recharge
    set_in(7'b0000000);
    clk1();
    chk_phase("R10", 3'b111);
    set_in(7'b1000010);
    clk1();
    chk_phase("R10", 3'b111);
    set_in(7'b0000001);
    clk1();
    chk_phase("R10", 3'b000);
    set_in(7'b0000000);
    clk1();
    chk_phase("R10", 3'b000);

    // R6: fast constant-current timeout boundary
    set_in(7'b1000000);
    clk1();
    chk_phase("R2", 3'b010);
    ticks(FL - 1);
    clk1();
    chk_phase("R6", 3'b010);
    ticks(1);
    clk1();
    chk_phase("R6", 3'b111);

    // R7: fast timer spans CC to CV, timeout in CV ends clean
    restart();
    set_in(7'b1000000);
    clk1();
    chk_phase("R2", 3'b010);
    ticks(FL - 2);
    set_in(7'b1001000);
    clk1();
    chk_phase("R5", 3'b100);
    ticks(1);
    clk1();
    chk_phase("R7", 3'b100);
    ticks(1);
    clk1();
    chk_phase("R7", 3'b101);

    // R9: recharge restarts in trickle for a dead cell
    set_in(7'b1110010);
    clk1();
    chk_phase("R9", 3'b001);

    // R11: done falls to idle when disabled
    restart();
    set_in(7'b1001000);
    clk1();
    clk1();
    set_in(7'b1001100);
    clk1();
    chk_phase("R8", 3'b101);
    set_in(7'b0001100);
    clk1();
    chk_phase("R11", 3'b000);

    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule